// File: doc/BRIEF.md
# Manchester Receive Bit Decoder

This block recovers bytes from a demodulated single-bit stream that carries Manchester code. It samples the line against the system clock through two flops and counts clock cycles between edges. Each interval is sorted into a half-cell span (T) or a whole-cell span (2T) using two separate programmable windows. A '0' cell has a rising edge at its centre and a '1' cell has a falling edge there. An edge at a cell boundary is legal only between two equal bits.

From start-up the decoder hunts for a preamble of '0' cells. Once it has locked, it waits for the first '1', which is the start bit. Data bits follow most significant bit first. Every eighth data bit yields a byte with a one-cycle valid strobe, and reception continues with the next byte without a new preamble. The decoder raises a one-cycle error pulse and drops back to preamble search in three cases: an interval that fits neither window, a missing centre edge, or a line that goes quiet. A byte that was being assembled at that point is discarded.

Top module: `manch_rx`

## Requirements
- R1: During and right after reset, `byte_vld` and `bit_err` are low and `byte_data` is 0x00.
- R2: An edge interval N (clock cycles between edges of the synchronized line) counts as T when `t_min` <= N <= `t_max`. It counts as 2T when `w_min` <= N <= `w_max` and it is not already T. Jitter that stays inside the windows does not change the decoded data.
- R3: In start-up the decoder locks when a rising edge ends a T interval and at least PRE_EDGES consecutive T intervals came before it. That edge is taken as the centre of a '0' cell.
- R4: After lock, further '0' cells are ignored. The first falling centre edge is the start bit and is never output. The next centre edge is the first data bit.
- R5: A rising centre edge decodes as 0 and a falling centre edge decodes as 1. Bits fill the byte MSB first. `byte_data` changes only together with `byte_vld`.
- R6: `byte_vld` is high for exactly one cycle per eight data bits. Back-to-back bytes need no new preamble.
- R7: After lock, a bad edge interval makes `bit_err` high for one cycle. An interval is bad if it fits neither window, or if it is 2T when it starts at a boundary edge. The decoder then returns to start-up and the partial byte is never output.
- R8: After lock, `bit_err` also fires in two cases without an edge. After a boundary edge, no edge comes within `t_max` cycles. After a centre edge, no edge comes within `w_max` cycles.
- R9: In start-up, `bit_err` never fires and no byte is output, whatever the line does short of a lock.
- R10: An output caused by a line edge appears on the third rising clock edge after the first clock that samples the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Demodulated line, asynchronous to clk |
| t_min | input | CW | Lower bound of the half-cell window |
| t_max | input | CW | Upper bound of the half-cell window |
| w_min | input | CW | Lower bound of the whole-cell window |
| w_max | input | CW | Upper bound of the whole-cell window |
| byte_data | output | 8 | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe for a new byte |
| bit_err | output | 1 | One-cycle strobe for a bit error |

## Verification
The bench sends frames at two data rates, with and without jitter. A window compare that is off by one, or a wrong bit order, would show up there as wrong bytes. It inserts an interval between the two windows and a glitch just after a boundary edge. A decoder that tolerated either one would output the corrupted byte, or would emit no error pulse. It holds the line flat after a boundary edge, where a timeout measured against the wrong limit would fire late or not at all. It also feeds noise to an idle decoder, where a wrongly armed error path would pulse `bit_err` without any lock.

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int CW        = 10,
  parameter int PRE_EDGES = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] t_min,
  input  logic [CW-1:0] t_max,
  input  logic [CW-1:0] w_min,
  input  logic [CW-1:0] w_max,
  output logic [7:0]    byte_data,
  output logic          byte_vld,
  output logic          bit_err
);

  localparam logic [1:0] S_HUNT = 2'd0;
  localparam logic [1:0] S_PRE  = 2'd1;
  localparam logic [1:0] S_DATA = 2'd2;
  localparam int ZW = $clog2(PRE_EDGES + 1);
  localparam logic [ZW-1:0] ZLIM = ZW'(PRE_EDGES);

  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic [1:0]    st;
  logic          mid;
  logic [ZW-1:0] zc;
  logic [6:0]    sh;
  logic [2:0]    bc;

  wire           edge_w   = s2 ^ s3;
  wire           in_t     = (cnt >= t_min) && (cnt <= t_max);
  wire           in_w     = !in_t && (cnt >= w_min) && (cnt <= w_max);
  wire [CW-1:0]  lim      = mid ? w_max : t_max;
  wire           tmo      = !edge_w && (cnt > lim);
  wire           bnd_edge = edge_w && mid && in_t;
  wire           mid_edge = edge_w && ((mid && in_w) || (!mid && in_t));
  wire           bad      = tmo || (edge_w && !bnd_edge && !mid_edge);
  wire           bitv     = s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      cnt       <= '1;
      st        <= S_HUNT;
      mid       <= 1'b0;
      zc        <= '0;
      sh        <= '0;
      bc        <= '0;
      byte_data <= '0;
      byte_vld  <= 1'b0;
      bit_err   <= 1'b0;
    end else begin
      s1       <= din;
      s2       <= s1;
      s3       <= s2;
      byte_vld <= 1'b0;
      bit_err  <= 1'b0;
      if (edge_w) cnt <= CW'(1);
      else if (!(&cnt)) cnt <= cnt + 1'b1;

      if (st == S_HUNT) begin
        if (edge_w) begin
          if (in_t && s2 && zc >= ZLIM) begin
            st  <= S_PRE;
            mid <= 1'b1;
            zc  <= '0;
          end else if (in_t) begin
            if (zc < ZLIM) zc <= zc + 1'b1;
          end else begin
            zc <= '0;
          end
        end
      end else if (bad) begin
        bit_err <= 1'b1;
        st      <= S_HUNT;
        mid     <= 1'b0;
        zc      <= '0;
      end else if (bnd_edge) begin
        mid <= 1'b0;
      end else if (mid_edge) begin
        mid <= 1'b1;
        if (st == S_PRE) begin
          if (bitv) begin
            st <= S_DATA;
            bc <= '0;
          end
        end else begin
          sh <= {sh[5:0], bitv};
          bc <= bc + 1'b1;
          if (bc == 3'd7) begin
            byte_data <= {sh, bitv};
            byte_vld  <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic [7:0] byte_data,
  input logic       byte_vld,
  input logic       bit_err
);

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);                                   // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |=> !bit_err);                                     // R7
  AST_ERR_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> st == 2'd0);                                   // R7
  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd0 |=> !bit_err);                                  // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_data) |-> byte_vld);                         // R5
  AST_VLD_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(st) == 2'd2);                           // R4

endmodule

bind manch_rx manch_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st),
  .byte_data (byte_data),
  .byte_vld  (byte_vld),
  .bit_err   (bit_err)
);

// File: tb/test_manch_rx.sv
`timescale 1ns/1ps
module test_manch_rx;
  localparam int CW  = 10;
  localparam int PRE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic [CW-1:0] t_min = 10'd6, t_max = 10'd10, w_min = 10'd13, w_max = 10'd19;
  logic [7:0]    byte_data;
  logic          byte_vld, bit_err;

  manch_rx #(.CW(CW), .PRE_EDGES(PRE)) i_manch_rx (
    .clk(clk), .rst_n(rst_n), .din(din),
    .t_min(t_min), .t_max(t_max), .w_min(w_min), .w_max(w_max),
    .byte_data(byte_data), .byte_vld(byte_vld), .bit_err(bit_err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit run = 1'b0;
  bit wave[$];
  bit h[$];
  int n = 0;
  int m_st = 0, m_mid = 0, m_cnt = 1023, m_zc = 0, m_bc = 0;
  logic [7:0] m_sh = '0, e_data = '0;
  bit e_vld, e_err;
  int nerrs = 0;
  logic [7:0] got[$];

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic model_step();
    int m, iv, lim;
    bit cur, prv, ev, is_t, is_w, bad;
    m   = n - 3;
    cur = (m >= 0) ? h[m] : 1'b0;
    prv = (m >= 1) ? h[m-1] : 1'b0;
    ev  = cur != prv;
    iv  = m_cnt;
    e_vld = 1'b0;
    e_err = 1'b0;
    is_t = iv >= t_min && iv <= t_max;
    is_w = !is_t && iv >= w_min && iv <= w_max;
    if (m_st == 0) begin
      if (ev) begin
        if (is_t && cur && m_zc >= PRE) begin m_st = 1; m_mid = 1; m_zc = 0; end
        else if (is_t) begin if (m_zc < PRE) m_zc++; end
        else m_zc = 0;
      end
    end else begin
      lim = m_mid ? int'(w_max) : int'(t_max);
      bad = ev ? !((m_mid && (is_t || is_w)) || (!m_mid && is_t)) : (iv > lim);
      if (bad) begin
        e_err = 1'b1; m_st = 0; m_zc = 0; m_mid = 0;
      end else if (ev && m_mid && is_t) begin
        m_mid = 0;
      end else if (ev) begin
        m_mid = 1;
        if (m_st == 1) begin
          if (prv) begin m_st = 2; m_bc = 0; end
        end else begin
          m_sh = {m_sh[6:0], prv};
          m_bc++;
          if (m_bc == 8) begin e_vld = 1'b1; e_data = m_sh; m_bc = 0; end
        end
      end
    end
    if (ev) m_cnt = 1;
    else if (m_cnt < 1023) m_cnt++;
  endtask

  always @(negedge clk) if (run) begin
    if (wave.size() > 0) din = wave.pop_front();
    h.push_back(din);
    model_step();
    checks += 3;
    if (byte_vld !== e_vld) fail("R6/R10", "byte_vld", byte_vld, e_vld);
    if (bit_err !== e_err) fail("R7/R10", "bit_err", bit_err, e_err);
    if (byte_data !== e_data) fail("R5", "byte_data", byte_data, e_data);
    if (byte_vld === 1'b1) got.push_back(byte_data);
    if (bit_err === 1'b1) nerrs++;
    n++;
  end

  task automatic add_half(bit lvl, int len);
    for (int i = 0; i < len; i++) wave.push_back(lvl);
  endtask

  task automatic add_bit(bit b, int h1, int h2);
    add_half(b, h1);
    add_half(!b, h2);
  endtask

  task automatic add_frame(logic [7:0] d[$], int t, int jit);
    for (int i = 0; i < 8; i++) add_bit(1'b0, t + jit, t - jit);
    add_bit(1'b1, t + jit, t - jit);
    foreach (d[k])
      for (int b = 7; b >= 0; b--) add_bit(d[k][b], t + jit, t - jit);
  endtask

  task automatic finish_scn(string req, logic [7:0] exp[$], int exp_err, int idle);
    while (wave.size() > 0) @(negedge clk);
    repeat (idle) @(negedge clk);
    checks++;
    if (got.size() != exp.size()) fail(req, "byte count", got.size(), exp.size());
    else foreach (exp[k]) begin
      checks++;
      if (got[k] !== exp[k]) fail(req, "byte value", got[k], exp[k]);
    end
    checks++;
    if (nerrs != exp_err) fail(req, "error count", nerrs, exp_err);
    got.delete();
    nerrs = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks += 3;
    if (byte_vld !== 1'b0) fail("R1", "byte_vld", byte_vld, 0);
    if (bit_err !== 1'b0) fail("R1", "bit_err", bit_err, 0);
    if (byte_data !== 8'h00) fail("R1", "byte_data", byte_data, 0);
    rst_n = 1'b1;
    #1 run = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (byte_vld !== 1'b0 || bit_err !== 1'b0) fail("R1", "outputs after release", {byte_vld, bit_err}, 0);

    // R3 R4 R5 R6 R8: clean frame, timeout at end of stream
    add_frame('{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81}, 8, 0);
    finish_scn("R4", '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81}, 1, 60);

    // R2: jitter inside both windows
    add_frame('{8'h5A, 8'hC3}, 8, 2);
    finish_scn("R2", '{8'h5A, 8'hC3}, 1, 60);

    // R7: interval of 12 lies between the windows
    add_frame('{8'hF0}, 8, 0);
    add_bit(1'b1, 8, 8); add_bit(1'b0, 8, 8); add_bit(1'b1, 8, 8);
    add_bit(1'b1, 12, 8);
    finish_scn("R7", '{8'hF0}, 1, 60);

    // R8: no centre edge after a boundary edge
    add_frame('{8'h33}, 8, 0);
    add_bit(1'b0, 8, 8);
    add_half(1'b0, 24);
    add_half(1'b1, 8);
    finish_scn("R8", '{8'h33}, 1, 60);

    // R7: glitch right after a boundary edge
    add_frame('{8'h77}, 8, 0);
    add_half(1'b1, 3); add_half(1'b0, 2); add_half(1'b1, 3); add_half(1'b0, 8);
    finish_scn("R7", '{8'h77}, 1, 60);

    // R9: noise while searching for a preamble
    add_half(1'b1, 2); add_half(1'b0, 30); add_half(1'b1, 5); add_half(1'b0, 17);
    add_half(1'b1, 1); add_half(1'b0, 40); add_half(1'b1, 8); add_half(1'b0, 3);
    add_half(1'b1, 15); add_half(1'b0, 9); add_half(1'b1, 50); add_half(1'b0, 8);
    finish_scn("R9", '{}, 0, 60);

    // R2 R6: faster rate with new windows
    @(negedge clk);
    t_min = 10'd3; t_max = 10'd5; w_min = 10'd7; w_max = 10'd9;
    add_frame('{8'h12, 8'h34, 8'hEE}, 4, 0);
    finish_scn("R6", '{8'h12, 8'h34, 8'hEE}, 1, 60);

    run = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule